// File: doc/BRIEF.md
# Sample Buffer Watermark Notifier

A playback sample store that sits in front of a digital-to-analogue consumer. Producers push samples in parallel bursts, one per clock. The consumer drains them one per strobe. The block watches the fill level and tells the host when more data is wanted, using two programmed thresholds with hysteresis between them. A data-wanted status bit and an active-low interrupt fire when the level drops below the low threshold. After that, the block stays quiet until the level climbs back to the high threshold.

Both thresholds come in through one 16-bit write-only command word, and a flag bit in that word picks the threshold. Each write takes a fixed number of cycles to complete, and a busy line is held for that time. When the write completes, a ready status bit is set. Until both thresholds have been written after reset, the notifier stays unarmed.

The hysteresis machine has three states:
- UNARMED: the state after reset. It moves to ARMED once both thresholds are valid.
- ARMED: it moves to FIRED, and sets data-wanted, when level < low.
- FIRED: it moves back to ARMED when level >= high.

The command port has two states:
- IDLE: it moves to BUSY when a command write arrives.
- BUSY: it moves back to IDLE when its latency counter expires. On that exit it applies the command and sets ready.

Top module: `sbuf_wm_notifier`

## Requirements
- R1: The buffer holds at most 800 samples. A write while full is dropped, and the level stays at 800.
- R2: Samples leave in the order they were written, one per consumer strobe. `rd_data` always shows the oldest stored sample.
- R3: A write while full, or a read while empty, sets status bit 0 (drop error) after the next clock edge. The bit stays set until the status is read.
- R4: In a command word, bit 15 selects the threshold (1 = high, 0 = low) and bits 10:0 carry the value. A value above 800 is stored as 800.
- R5: A command word with any of bits 14:11 set changes no threshold. It still completes and sets ready.
- R6: After a command write, `cmd_busy` is high for exactly 4 cycles. Status bit 15 (ready) sets at the edge that ends busy, and command writes made while busy are ignored.
- R7: Data-wanted never sets until both the low and the high threshold have been written after reset.
- R8: While armed, status bit 8 (data-wanted) sets one edge after the level becomes strictly less than the low threshold.
- R9: Once data-wanted has fired, it does not fire again until the level has reached at least the high threshold.
- R10: `irq_n` is low while any status bit whose enable bit in `irq_en` is set is also set, and high otherwise.
- R11: A `stat_rd` strobe clears status bits 15, 8 and 0 at the next edge. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 16 | Sample to store |
| rd_stb | input | 1 | Consumer read strobe |
| rd_data | output | 16 | Oldest stored sample |
| level | output | 10 | Current fill count |
| cmd_we | input | 1 | Threshold command write strobe |
| cmd_data | input | 16 | Threshold command word |
| cmd_busy | output | 1 | Command in progress |
| stat_rd | input | 1 | Status read strobe (clears on read) |
| status | output | 16 | Bit 15 ready, bit 8 data-wanted, bit 0 drop error |
| irq_en | input | 16 | Per-bit interrupt enables |
| irq_n | output | 1 | Active-low interrupt |

## Verification
All results are due a fixed number of cycles after their stimulus:
- The level and the drop error bit change at the edge that takes the write or read.
- `cmd_busy` rises at the edge that takes the command and falls four edges later.
- Ready appears together with the fall of `cmd_busy`.
- Arming takes one more edge after the second threshold is applied, so on an already-low buffer data-wanted appears two edges after ready.
- Otherwise, data-wanted appears one edge after the level drops below the low threshold.
- `irq_n` follows status in the same cycle.

The bench drives inputs and samples outputs on falling edges and counts the rising edges between them. Each check is therefore taken in the exact cycle named above. Quiet periods are also sampled to confirm that nothing fires early.

// File: rtl/sbuf_wm_pkg.sv
package sbuf_wm_pkg;
    typedef enum logic [1:0] {HY_UNARMED, HY_ARMED, HY_FIRED} hyst_state_t;
    typedef enum logic {CP_IDLE, CP_BUSY} cmd_state_t;
    localparam int ST_RDY  = 15;
    localparam int ST_WANT = 8;
    localparam int ST_ERR  = 0;
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 800,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  level,
    output logic              drop
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, empty, push, pop;

    always_comb begin
        full  = (level == CNT_W'(DEPTH));
        empty = (level == '0);
        push  = push_req && !full;
        pop   = pop_req && !empty;
        drop  = (push_req && full) || (pop_req && empty);
    end

    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    // R1
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    // R1
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CNT_W'(DEPTH) && push_req && !pop_req) |=> level == CNT_W'(DEPTH));
endmodule

// File: rtl/wm_cmd_port.sv
module wm_cmd_port
    import sbuf_wm_pkg::*;
#(
    parameter int DEPTH = 800,
    parameter int WM_W  = 11,
    parameter int CMD_W = 16,
    parameter int LAT   = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] lo_val,
    output logic [CNT_W-1:0] hi_val,
    output logic             lo_ok,
    output logic             hi_ok
);
    localparam int LW = (LAT > 1) ? $clog2(LAT) : 1;

    cmd_state_t       st, st_nx;
    logic [CMD_W-1:0] cmd_q;
    logic [LW-1:0]    lat_cnt;
    logic [CNT_W-1:0] clamp_val;
    logic             rsvd_bad, sel_hi;

    always_comb begin
        rsvd_bad  = |cmd_q[CMD_W-2:WM_W];
        sel_hi    = cmd_q[CMD_W-1];
        clamp_val = (cmd_q[WM_W-1:0] > WM_W'(DEPTH)) ? CNT_W'(DEPTH) : cmd_q[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CP_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        busy  = 1'b0;
        done  = 1'b0;
        unique case (st)
            CP_IDLE: if (cmd_we) st_nx = CP_BUSY;
            CP_BUSY: begin
                busy = 1'b1;
                if (lat_cnt == '0) begin
                    done  = 1'b1;
                    st_nx = CP_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            lat_cnt <= '0;
            lo_val  <= '0;
            hi_val  <= '0;
            lo_ok   <= 1'b0;
            hi_ok   <= 1'b0;
        end else begin
            if (st == CP_IDLE && cmd_we) begin
                cmd_q   <= cmd_word;
                lat_cnt <= LW'(LAT - 1);
            end else if (st == CP_BUSY && lat_cnt != '0) begin
                lat_cnt <= lat_cnt - 1'b1;
            end
            if (done && !rsvd_bad) begin
                if (sel_hi) begin
                    hi_val <= clamp_val;
                    hi_ok  <= 1'b1;
                end else begin
                    lo_val <= clamp_val;
                    lo_ok  <= 1'b1;
                end
            end
        end
    end

    // R6
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R5
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsvd_bad) |=> ($stable(lo_val) && $stable(hi_val)));
endmodule

// File: rtl/wm_hyst_fsm.sv
module wm_hyst_fsm
    import sbuf_wm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] lo_val,
    input  logic [CNT_W-1:0] hi_val,
    input  logic             lo_ok,
    input  logic             hi_ok,
    output logic             fire
);
    hyst_state_t st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= HY_UNARMED;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        fire  = 1'b0;
        unique case (st)
            HY_UNARMED: if (lo_ok && hi_ok) st_nx = HY_ARMED;
            HY_ARMED: if (level < lo_val) begin
                fire  = 1'b1;
                st_nx = HY_FIRED;
            end
            HY_FIRED: if (level >= hi_val) st_nx = HY_ARMED;
            default: st_nx = HY_UNARMED;
        endcase
    end

    // R7
    no_fire_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (lo_ok && hi_ok));

    // R9
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/sbuf_wm_notifier.sv
module sbuf_wm_notifier
    import sbuf_wm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 800,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level,
    input  logic              cmd_we,
    input  logic [15:0]       cmd_data,
    output logic              cmd_busy,
    input  logic              stat_rd,
    output logic [15:0]       status,
    input  logic [15:0]       irq_en,
    output logic              irq_n
);
    logic             drop, done, fire, lo_ok, hi_ok;
    logic [CNT_W-1:0] lo_val, hi_val;
    logic             rdy_q, want_q, err_q;

    sbuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(wr_en), .push_data(wr_data),
        .pop_req(rd_stb), .pop_data(rd_data), .level(level), .drop(drop));

    wm_cmd_port #(.DEPTH(DEPTH), .WM_W(11), .CMD_W(16), .LAT(LAT), .CNT_W(CNT_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_data),
        .busy(cmd_busy), .done(done), .lo_val(lo_val), .hi_val(hi_val),
        .lo_ok(lo_ok), .hi_ok(hi_ok));

    wm_hyst_fsm #(.CNT_W(CNT_W)) u_hyst (
        .clk(clk), .rst_n(rst_n), .level(level), .lo_val(lo_val), .hi_val(hi_val),
        .lo_ok(lo_ok), .hi_ok(hi_ok), .fire(fire));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q  <= 1'b0;
            want_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            rdy_q  <= done || (rdy_q && !stat_rd);
            want_q <= fire || (want_q && !stat_rd);
            err_q  <= drop || (err_q && !stat_rd);
        end
    end

    always_comb begin
        status          = '0;
        status[ST_RDY]  = rdy_q;
        status[ST_WANT] = want_q;
        status[ST_ERR]  = err_q;
        irq_n           = ~|(status & irq_en);
    end

    // R10
    irq_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && irq_en[ST_WANT]) |=> !irq_n);

    // R3
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> status[ST_ERR]);

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !fire && !done && !drop) |=> (status == 16'h0000));
endmodule

// File: tb/sbuf_wm_notifier_bench.sv
module sbuf_wm_notifier_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_data;
    logic [9:0]  level;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        cmd_busy;
    logic        stat_rd = 1'b0;
    logic [15:0] status;
    logic [15:0] irq_en = 16'h8101;
    logic        irq_n;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    sbuf_wm_notifier u_sbuf_wm_notifier (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .level(level),
        .cmd_we(cmd_we), .cmd_data(cmd_data), .cmd_busy(cmd_busy),
        .stat_rd(stat_rd), .status(status), .irq_en(irq_en), .irq_n(irq_n));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_n(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1;
            wr_data = 16'(base + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic pop_n(input int n);
        for (int i = 0; i < n; i++) begin
            rd_stb = 1'b1;
            @(negedge clk);
        end
        rd_stb = 1'b0;
    endtask

    task automatic read_clear();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    // Command write with R6 timing checks; ends after a clearing status read.
    task automatic send_cmd(input logic [15:0] w);
        cmd_we = 1'b1;
        cmd_data = w;
        @(negedge clk);
        cmd_we = 1'b0;
        chk("R6 busy edge1", int'(cmd_busy), 1);
        for (int i = 0; i < 3; i++) begin
            if (i == 1) begin
                cmd_we = 1'b1;
                cmd_data = 16'h0000;
            end
            @(negedge clk);
            cmd_we = 1'b0;
            chk("R6 busy held", int'(cmd_busy), 1);
        end
        @(negedge clk);
        chk("R6 busy done", int'(cmd_busy), 0);
        chk("R6 ready set", int'(status[15]), 1);
        chk("R10 irq on ready", int'(irq_n), 0);
        read_clear();
        chk("R11 status cleared", int'(status), 0);
        chk("R10 irq released", int'(irq_n), 1);
    endtask

    task automatic t_reset();
        chk("R1 reset level", int'(level), 0);
        chk("R11 reset status", int'(status), 0);
        chk("R10 reset irq", int'(irq_n), 1);
        chk("R6 reset busy", int'(cmd_busy), 0);
    endtask

    task automatic t_order();
        push_n(8, 16'h1230);
        chk("R2 level after burst", int'(level), 8);
        for (int i = 0; i < 8; i++) begin
            chk("R2 head data", int'(rd_data), 16'h1230 + i);
            pop_n(1);
        end
        chk("R2 level drained", int'(level), 0);
        chk("R3 no error", int'(status[0]), 0);
    endtask

    task automatic t_underflow();
        pop_n(1);
        chk("R3 empty read error", int'(status[0]), 1);
        chk("R1 level stays 0", int'(level), 0);
        chk("R10 irq on error", int'(irq_n), 0);
        @(negedge clk);
        chk("R3 error sticky", int'(status[0]), 1);
        read_clear();
        chk("R11 error cleared", int'(status[0]), 0);
        chk("R10 irq released", int'(irq_n), 1);
    endtask

    task automatic t_unarmed();
        send_cmd(16'h0005);
        repeat (4) @(negedge clk);
        chk("R7 low only no fire", int'(status[8]), 0);
    endtask

    task automatic t_reserved();
        send_cmd(16'h8814);
        repeat (4) @(negedge clk);
        chk("R5 reserved write ignored", int'(status[8]), 0);
    endtask

    task automatic t_arm_fire();
        send_cmd(16'h87D0);
        @(negedge clk);
        chk("R8 fire two edges after ready", int'(status[8]), 1);
        chk("R10 irq on wanted", int'(irq_n), 0);
        read_clear();
        chk("R11 wanted cleared", int'(status[8]), 0);
    endtask

    task automatic t_hysteresis();
        push_n(3, 0);
        repeat (3) @(negedge clk);
        chk("R9 no refire below low", int'(status[8]), 0);
        push_n(797, 100);
        chk("R1 full level", int'(level), 800);
        push_n(1, 0);
        chk("R1 write when full dropped", int'(level), 800);
        chk("R3 full write error", int'(status[0]), 1);
        read_clear();
        pop_n(795);
        chk("R4 level at low", int'(level), 5);
        repeat (2) @(negedge clk);
        chk("R8 no fire at level equal low", int'(status[8]), 0);
        pop_n(1);
        chk("R8 no fire same edge", int'(status[8]), 0);
        @(negedge clk);
        chk("R4 R8 rearmed after clamped high", int'(status[8]), 1);
        chk("R10 irq on wanted", int'(irq_n), 0);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(negedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_underflow();
        t_unarmed();
        t_reserved();
        t_arm_fire();
        t_hysteresis();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule